// File: doc/BRIEF.md
# Frame-Counted Periodic Interrupt Timer

The block counts frame boundaries, one per 250 µs frame tick, and fires an expiry event once every programmable number of frames. It runs without software help: after each expiry it reloads itself from the period register and keeps going, so the processor gets a steady interrupt at a fixed frame interval anywhere from one frame (250 µs) to 128 frames (32 ms).

Each expiry is used three ways. It sets a sticky interrupt that software clears. It raises a multiframe sync pulse that lasts exactly one frame. It gives a one-clock "final sample" strobe that signaling-channel evaluation logic uses to mark the end of its observation window. Software sets the period through a 7-bit write port and can pause counting with an enable input. A new period is taken into the counter at the next counted frame tick.

Top module: `frame_period_timer`

## Requirements
- R1: After reset `irq`, `mf_pulse` and `last_look` are 0, the period register holds 127, and the first expiry comes on the 128th enabled frame tick.
- R2: With period field value N (7 bits, 0..127), expiries come on every (N+1)th enabled frame tick, so the period spans 1 to 128 frames.
- R3: After an expiry the counter reloads from the period register on the same tick, and expiries repeat with no further write.
- R4: A write of `period_wdata` with `period_wr` high sets a pending reload. The next enabled frame tick that comes in a later cycle loads the new value, raises no expiry, and clears the pending reload. The first expiry after that comes N+1 enabled ticks later. A write in the same cycle as an enabled tick does not affect that tick.
- R5: `irq` rises in the cycle after an expiry tick and stays high until a cycle with `irq_clr` high and no new expiry. An expiry in the same cycle as a clear wins.
- R6: `mf_pulse` goes high in the cycle after an expiry tick and goes low in the cycle after the next frame tick. It changes only in the cycle after a frame tick.
- R7: `last_look` is high for exactly the one clock cycle after each expiry tick, and at no other time.
- R8: While `enable` is low, frame ticks neither advance the counter nor cause an expiry. The count is kept and resumes when `enable` returns high.
- R9: A period written while `enable` is low stays pending and is loaded at the first enabled frame tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_tick | input | 1 | One-cycle pulse per 250 µs frame |
| enable | input | 1 | Counting enable |
| period_wr | input | 1 | Write strobe for the period value |
| period_wdata | input | 7 | Period field N; period is N+1 frames |
| irq_clr | input | 1 | Clears the interrupt |
| irq | output | 1 | Sticky periodic interrupt |
| mf_pulse | output | 1 | One-frame-wide multiframe sync |
| last_look | output | 1 | One-clock marker of the final sample window |

## Verification
The bench looks at the edges of the reload logic. It tests period 0, where every enabled tick expires and a counter that skips the zero state would fire half as often. It tests writes that land on the same cycle as a tick, where a design that loads at once would shift every later expiry by one frame. It also checks that the full 128-frame reset period does not wrap early. It asserts a clear and an expiry together, where a design that gives the clear priority would lose an interrupt. It also drops `enable` in mid-count, where a design that resets the count, or keeps counting, would put expiries at the wrong frame.

// File: rtl/ft_pkg.sv
package ft_pkg;
  localparam int FT_PERIOD_W   = 7;
  localparam int FT_RST_PERIOD = (1 << FT_PERIOD_W) - 1;
  localparam int FT_SYNC_STAGES = 2;
endpackage

// File: rtl/ft_period_reg.sv
module ft_period_reg #(
  parameter int W       = ft_pkg::FT_PERIOD_W,
  parameter int RST_VAL = ft_pkg::FT_RST_PERIOD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         step,
  output logic [W-1:0] period_q,
  output logic         pend_q
);
  logic [W-1:0] period_d;
  logic         pend_d;

  always_comb begin
    period_d = period_q;
    pend_d   = pend_q;
    if (wr) begin
      period_d = wdata;
      pend_d   = 1'b1;
    end else if (step) begin
      pend_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= W'(RST_VAL);
      pend_q   <= 1'b0;
    end else begin
      period_q <= period_d;
      pend_q   <= pend_d;
    end
  end
endmodule

// File: rtl/ft_down_counter.sv
module ft_down_counter #(
  parameter int W       = ft_pkg::FT_PERIOD_W,
  parameter int RST_VAL = ft_pkg::FT_RST_PERIOD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         reload_pend,
  input  logic [W-1:0] period,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (step) begin
      if (reload_pend) begin
        cnt_d = period;
      end else if (at_zero) begin
        cnt_d  = period;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ft_event_out.sv
module ft_event_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic expire,
  input  logic irq_clr,
  output logic irq_q,
  output logic mf_q,
  output logic ll_q
);
  logic irq_d;
  logic mf_d;
  logic ll_d;

  always_comb begin
    irq_d = expire | (irq_q & ~irq_clr);
    mf_d  = tick ? expire : mf_q;
    ll_d  = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      mf_q  <= 1'b0;
      ll_q  <= 1'b0;
    end else begin
      irq_q <= irq_d;
      mf_q  <= mf_d;
      ll_q  <= ll_d;
    end
  end
endmodule

// File: rtl/frame_period_timer.sv
module frame_period_timer #(
  parameter int PERIOD_W    = ft_pkg::FT_PERIOD_W,
  parameter int RST_PERIOD  = ft_pkg::FT_RST_PERIOD,
  parameter int SYNC_STAGES = ft_pkg::FT_SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  input  logic                enable,
  input  logic                period_wr,
  input  logic [PERIOD_W-1:0] period_wdata,
  input  logic                irq_clr,
  output logic                irq,
  output logic                mf_pulse,
  output logic                last_look
);
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_n_int;
  logic                   step;
  logic                   expire;
  logic                   pend;
  logic [PERIOD_W-1:0]    period;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[SYNC_STAGES-1];

  assign step = frame_tick & enable;

  ft_period_reg #(.W(PERIOD_W), .RST_VAL(RST_PERIOD)) u_preg (
    .clk(clk), .rst_n(rst_n_int), .wr(period_wr), .wdata(period_wdata),
    .step(step), .period_q(period), .pend_q(pend)
  );

  ft_down_counter #(.W(PERIOD_W), .RST_VAL(RST_PERIOD)) u_cnt (
    .clk(clk), .rst_n(rst_n_int), .step(step), .reload_pend(pend),
    .period(period), .expire(expire)
  );

  ft_event_out u_evt (
    .clk(clk), .rst_n(rst_n_int), .tick(frame_tick), .expire(expire),
    .irq_clr(irq_clr), .irq_q(irq), .mf_q(mf_pulse), .ll_q(last_look)
  );
endmodule

// File: rtl/frame_period_timer_chk.sv
module frame_period_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_tick,
  input logic enable,
  input logic irq_clr,
  input logic irq,
  input logic mf_pulse,
  input logic last_look
);
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R5
  AST_IRQ_RISE_WITH_LL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> last_look); // R5
  AST_LL_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    last_look |-> ($past(frame_tick) && $past(enable))); // R7
  AST_LL_IN_MF: assert property (@(posedge clk) disable iff (!rst_n)
    last_look |-> mf_pulse); // R6
  AST_MF_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(mf_pulse)); // R6
  AST_LL_CAUSES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    last_look |-> irq); // R5
endmodule

bind frame_period_timer frame_period_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .enable(enable),
  .irq_clr(irq_clr), .irq(irq), .mf_pulse(mf_pulse), .last_look(last_look)
);

// File: tb/test_frame_period_timer.sv
module test_frame_period_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic       enable = 1'b0;
  logic       period_wr = 1'b0;
  logic [6:0] period_wdata = '0;
  logic       irq_clr = 1'b0;
  logic       irq, mf_pulse, last_look;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state, from the requirements
  int m_period, m_cnt;
  bit m_pend, m_irq, m_mf, m_ll;

  always #4 clk = ~clk;

  frame_period_timer i_frame_period_timer (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .enable(enable),
    .period_wr(period_wr), .period_wdata(period_wdata), .irq_clr(irq_clr),
    .irq(irq), .mf_pulse(mf_pulse), .last_look(last_look)
  );

  task automatic check(string tag, string what, bit act, bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_period = 127; m_cnt = 127; m_pend = 0; m_irq = 0; m_mf = 0; m_ll = 0;
  endtask

  function automatic bit model_expire(bit tk, bit en);
    return tk && en && !m_pend && (m_cnt == 0);
  endfunction

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(bit tk, bit en, bit wr, bit [6:0] wd, bit clr, string tag);
    bit ex;
    frame_tick = tk; enable = en; period_wr = wr; period_wdata = wd; irq_clr = clr;
    @(posedge clk);
    ex = model_expire(tk, en);
    if (tk && en) begin
      if (m_pend || m_cnt == 0) m_cnt = m_period;
      else m_cnt = m_cnt - 1;
    end
    if (wr) begin m_pend = 1; m_period = wd; end
    else if (tk && en) m_pend = 0;
    m_irq = ex | (m_irq & ~clr);
    if (tk) m_mf = ex;
    m_ll = ex;
    @(negedge clk);
    check(tag, "irq", irq, m_irq);
    check(tag, "mf_pulse", mf_pulse, m_mf);
    check(tag, "last_look", last_look, m_ll);
  endtask

  task automatic frames(int n, int gap, bit en, string tag);
    for (int i = 0; i < n; i++) begin
      step(1, en, 0, 0, 0, tag);
      for (int g = 0; g < gap; g++) step(0, en, 0, 0, 0, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt_ll;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: outputs idle after reset
    check("R1", "irq", irq, 0);
    check("R1", "mf_pulse", mf_pulse, 0);
    check("R1", "last_look", last_look, 0);
    // R1: default period 128 frames; no expiry before tick 128
    frames(127, 2, 1, "R1");
    check("R1", "no early last_look", last_look, 0);
    step(1, 1, 0, 0, 0, "R1");
    check("R1", "last_look on tick 128", last_look, 1);
    step(0, 1, 0, 0, 1, "R5"); // R5 clear
    // R4: write period 3 on a tick cycle; that tick is unaffected
    step(1, 1, 1, 7'd3, 0, "R4");
    frames(12, 1, 1, "R4");
    // R2/R3: period 0, every enabled tick expires, repeatedly
    step(0, 1, 1, 7'd0, 0, "R2");
    cnt_ll = 0;
    for (int i = 0; i < 6; i++) begin
      step(1, 1, 0, 0, 0, "R3");
      if (i > 0 && last_look) cnt_ll++;
      step(0, 1, 0, 0, 0, "R3");
    end
    check("R2", "period-0 expiry count", cnt_ll == 5, 1);
    // R5: clear coincident with expiry, expiry wins
    step(1, 1, 0, 0, 1, "R5");
    check("R5", "irq set over clear", irq, 1);
    // R8: disabled ticks hold the count
    step(0, 1, 1, 7'd5, 0, "R8");
    frames(3, 1, 1, "R8");
    frames(10, 1, 0, "R8");
    frames(8, 1, 1, "R8");
    // R9: write while disabled, loaded at first enabled tick
    step(0, 0, 1, 7'd2, 0, "R9");
    frames(4, 1, 0, "R9");
    frames(9, 1, 1, "R9");
    // R7 and all: constrained random
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 30000; i++) begin
      bit tk, en, wr, clr;
      bit [6:0] wd;
      tk  = ($urandom % 4) == 0;
      en  = ($urandom % 8) != 0;
      wr  = ($urandom % 200) == 0;
      clr = ($urandom % 6) == 0;
      wd  = (($urandom % 10) == 0) ? 7'($urandom) : 7'($urandom % 6);
      step(tk, en, wr, wd, clr, "R7");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule